// File: doc/BRIEF.md
# Framed Message Integrity Checker

This block sits above a byte-level two-wire serial slave engine. It checks a framing layer carried on top of plain byte transfers. The engine hands it a byte stream marked with start, stop and lost-arbitration events. The block follows each frame through five parts in order: address, byte count, payload, and two check bytes. It recomputes a CRC-16 over the frame and holds the sender to the declared length. On critical command messages it also checks that the second payload byte is the bitwise complement of the first.

Payload bytes are forwarded with a strobe as they arrive. Each frame ends with one verdict pulse that carries a 3-bit error code. Downstream logic keeps the payload only when the code is zero. A frame cut short by lost arbitration, or replaced by a repeated start, is dropped without a verdict. A frame left open past an idle limit is closed with a timeout verdict.

Top module: `frame_guard`

## Requirements
- R1: After reset, `done`, `pay_valid` and `err_code` are all low.
- R2: In a well-formed frame, each payload byte appears on `pay_data` with `pay_valid` for one cycle, one cycle after it is received and in arrival order. One cycle after the stop event, `done` pulses for exactly one cycle with code 0. `err_code` is 0 whenever `done` is low.
- R3: A count byte of 0 or greater than `MAX_LEN` gives `done` with code 1 one cycle after the count byte. The rest of that frame produces no payload and no further verdict.
- R4: A stop event after the address byte but before the count byte plus count+2 further bytes have all arrived gives code 2.
- R5: A byte received after the second check byte gives code 3 one cycle later. The later stop of that frame produces no further verdict.
- R6: The check word is CRC-16, polynomial 0x1021, initial value 0xFFFF, processed MSB first. It covers the address, count and payload bytes and is sent high byte first. A mismatch found at stop gives code 4.
- R7: When the first payload byte is 0xF0 or above, the second payload byte must equal its bitwise inverse, or the frame gets code 5. A CRC mismatch takes precedence over this. Frames whose first payload byte is below 0xF0 are not checked this way.
- R8: A lost-arbitration event discards the open frame with no verdict, and a following frame is checked normally.
- R9: In an open frame, if no byte arrives for `BYTE_CYCLES*TIMEOUT_BYTES` cycles after the last start or byte, `done` pulses with code 6 and the frame is closed.
- R10: A start event inside an open frame drops that frame without a verdict and begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_start | input | 1 | Start (or repeated start) event, one cycle |
| frm_stop | input | 1 | Stop event, one cycle |
| frm_abort | input | 1 | Arbitration lost, discard current frame |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| pay_valid | output | 1 | Payload byte strobe |
| pay_data | output | 8 | Payload byte |
| done | output | 1 | One-cycle end-of-frame verdict |
| err_code | output | 3 | 0 ok, 1 length, 2 short, 3 overrun, 4 CRC, 5 complement, 6 timeout |

## Verification
The bench builds the block with `MAX_LEN` = 8, `BYTE_CYCLES` = 4 and `TIMEOUT_BYTES` = 3. The length limit and its first illegal value then sit only a few bytes apart. The 12-cycle idle limit lets the timeout verdict be checked at its exact cycle. The complement check stays enabled, so frames with and without a critical opcode each meet it.

// File: rtl/fg_pkg.sv
package fg_pkg;

   typedef enum logic [2:0] {
      FG_OK      = 3'd0,
      FG_LEN     = 3'd1,
      FG_SHORT   = 3'd2,
      FG_OVERRUN = 3'd3,
      FG_CRC     = 3'd4,
      FG_CMP     = 3'd5,
      FG_TIMEOUT = 3'd6
   } fg_err_e;

   typedef enum logic [2:0] {
      S_IDLE, S_ADDR, S_COUNT, S_DATA, S_CRCH, S_CRCL, S_TAIL, S_SKIP
   } fg_state_e;

   // One byte through a MSB-first CRC-16 register
   function automatic logic [15:0] fg_crc_step(input logic [15:0] cur,
                                               input logic [7:0]  b,
                                               input logic [15:0] poly);
      logic [15:0] r;
      r = cur ^ {b, 8'h00};
      for (int i = 0; i < 8; i++)
         r = r[15] ? ((r << 1) ^ poly) : (r << 1);
      return r;
   endfunction

endpackage

// File: rtl/fg_crc.sv
module fg_crc #(
   parameter logic [15:0] POLY = 16'h1021,
   parameter logic [15:0] INIT = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   import fg_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= INIT;
      else if (clr) crc <= INIT;
      else if (en)  crc <= fg_crc_step(crc, din, POLY);
   end

endmodule

// File: rtl/fg_timer.sv
module fg_timer #(
   parameter int LIMIT = 90000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic kick,
   output logic expire
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

   generate
      if (LIMIT == 0) begin : g_off
         assign expire = 1'b0;
      end else begin : g_on
         logic [CW-1:0] cnt_q;

         assign expire = armed && !kick && (cnt_q == CW'(LIMIT - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt_q <= '0;
            else if (kick)       cnt_q <= '0;
            else if (armed && !expire) cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/fg_seq.sv
module fg_seq #(
   parameter int         MAX_LEN   = 32,
   parameter logic [7:0] CRIT_BASE = 8'hF0,
   parameter bit         CMP_CHECK = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_ev,
   input  logic        stop_ev,
   input  logic        abort_ev,
   input  logic        byte_ev,
   input  logic [7:0]  byte_val,
   input  logic        expire,
   input  logic [15:0] crc_now,
   output logic        crc_clr,
   output logic        crc_en,
   output logic        armed,
   output logic        pay_valid,
   output logic [7:0]  pay_data,
   output logic        done,
   output logic [2:0]  err_code
);
   import fg_pkg::*;

   localparam int RW = $clog2(MAX_LEN + 1);

   fg_state_e     st_q;
   logic [RW-1:0] rem_q;
   logic [1:0]    seen_q;
   logic [7:0]    first_q;
   logic          crit_q;
   logic          pair_ok_q;
   logic [15:0]   rx_crc_q;
   logic          cmp_bad;
   logic          plain_byte;

   generate
      if (CMP_CHECK) begin : g_cmp
         assign cmp_bad = crit_q && !pair_ok_q;
      end else begin : g_nocmp
         assign cmp_bad = 1'b0;
      end
   endgenerate

   assign plain_byte = byte_ev && !abort_ev && !start_ev && !stop_ev;
   assign crc_clr    = start_ev && !abort_ev;
   assign crc_en     = plain_byte &&
                       (st_q == S_ADDR || st_q == S_COUNT || st_q == S_DATA);
   assign armed      = (st_q != S_IDLE) && (st_q != S_SKIP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         rem_q     <= '0;
         seen_q    <= '0;
         first_q   <= '0;
         crit_q    <= 1'b0;
         pair_ok_q <= 1'b0;
         rx_crc_q  <= '0;
         pay_valid <= 1'b0;
         pay_data  <= '0;
         done      <= 1'b0;
         err_code  <= FG_OK;
      end else begin
         pay_valid <= 1'b0;
         done      <= 1'b0;
         err_code  <= FG_OK;
         if (abort_ev) begin
            st_q <= S_IDLE;
         end else if (start_ev) begin
            st_q      <= S_ADDR;
            seen_q    <= '0;
            crit_q    <= 1'b0;
            pair_ok_q <= 1'b0;
         end else if (stop_ev) begin
            st_q <= S_IDLE;
            case (st_q)
               S_COUNT, S_DATA, S_CRCH, S_CRCL: begin
                  done     <= 1'b1;
                  err_code <= FG_SHORT;
               end
               S_TAIL: begin
                  done <= 1'b1;
                  if (rx_crc_q != crc_now) err_code <= FG_CRC;
                  else if (cmp_bad)        err_code <= FG_CMP;
                  else                     err_code <= FG_OK;
               end
               default: ;
            endcase
         end else if (byte_ev) begin
            case (st_q)
               S_ADDR: st_q <= S_COUNT;
               S_COUNT: begin
                  if (byte_val == 8'd0 || int'(byte_val) > MAX_LEN) begin
                     done     <= 1'b1;
                     err_code <= FG_LEN;
                     st_q     <= S_SKIP;
                  end else begin
                     rem_q <= byte_val[RW-1:0];
                     st_q  <= S_DATA;
                  end
               end
               S_DATA: begin
                  pay_valid <= 1'b1;
                  pay_data  <= byte_val;
                  if (seen_q == 2'd0) begin
                     first_q <= byte_val;
                     crit_q  <= (byte_val >= CRIT_BASE);
                  end
                  if (seen_q == 2'd1)
                     pair_ok_q <= (byte_val == ~first_q);
                  if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
                  rem_q <= rem_q - RW'(1);
                  if (rem_q == RW'(1)) st_q <= S_CRCH;
               end
               S_CRCH: begin
                  rx_crc_q[15:8] <= byte_val;
                  st_q           <= S_CRCL;
               end
               S_CRCL: begin
                  rx_crc_q[7:0] <= byte_val;
                  st_q          <= S_TAIL;
               end
               S_TAIL: begin
                  done     <= 1'b1;
                  err_code <= FG_OVERRUN;
                  st_q     <= S_SKIP;
               end
               default: ;
            endcase
         end else if (expire) begin
            done     <= 1'b1;
            err_code <= FG_TIMEOUT;
            st_q     <= S_IDLE;
         end
      end
   end

endmodule

// File: rtl/frame_guard.sv
module frame_guard #(
   parameter int          MAX_LEN       = 32,
   parameter logic [7:0]  CRIT_BASE     = 8'hF0,
   parameter bit          CMP_CHECK     = 1'b1,
   parameter logic [15:0] CRC_POLY      = 16'h1021,
   parameter logic [15:0] CRC_INIT      = 16'hFFFF,
   parameter int          BYTE_CYCLES   = 9000,
   parameter int          TIMEOUT_BYTES = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frm_start,
   input  logic       frm_stop,
   input  logic       frm_abort,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   output logic       pay_valid,
   output logic [7:0] pay_data,
   output logic       done,
   output logic [2:0] err_code
);
   localparam int IDLE_LIMIT = BYTE_CYCLES * TIMEOUT_BYTES;

   generate
      if (MAX_LEN < 1 || MAX_LEN > 255) begin : g_bad_len
         $error("frame_guard: MAX_LEN must lie in 1..255");
      end
      if (BYTE_CYCLES < 1 || TIMEOUT_BYTES < 0) begin : g_bad_tmo
         $error("frame_guard: BYTE_CYCLES >= 1 and TIMEOUT_BYTES >= 0 required");
      end
   endgenerate

   logic        crc_clr, crc_en, armed, expire;
   logic [15:0] crc_now;

   fg_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
      .din(rx_data), .crc(crc_now)
   );

   fg_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
      .clk(clk), .rst_n(rst_n), .armed(armed),
      .kick(rx_valid || frm_start), .expire(expire)
   );

   fg_seq #(.MAX_LEN(MAX_LEN), .CRIT_BASE(CRIT_BASE), .CMP_CHECK(CMP_CHECK)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start_ev(frm_start), .stop_ev(frm_stop), .abort_ev(frm_abort),
      .byte_ev(rx_valid), .byte_val(rx_data),
      .expire(expire), .crc_now(crc_now),
      .crc_clr(crc_clr), .crc_en(crc_en), .armed(armed),
      .pay_valid(pay_valid), .pay_data(pay_data),
      .done(done), .err_code(err_code)
   );

endmodule

// File: rtl/frame_guard_sva.sv
module frame_guard_sva (
   input logic       clk,
   input logic       rst_n,
   input logic       frm_start,
   input logic       frm_stop,
   input logic       frm_abort,
   input logic       rx_valid,
   input logic       pay_valid,
   input logic       done,
   input logic [2:0] err_code
);
   assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_code_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> err_code == 3'd0);

   assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> err_code <= 3'd6);

   assert_len_on_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_code == 3'd1) |-> $past(rx_valid));

   assert_pay_not_with_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(pay_valid && done));

   assert_short_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_code == 3'd2) |-> $past(frm_stop));

   assert_overrun_on_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_code == 3'd3) |-> $past(rx_valid));

   assert_abort_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frm_abort |=> !done && !pay_valid);

   assert_restart_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_start && !frm_abort) |=> !done);

endmodule

bind frame_guard frame_guard_sva u_sva (
   .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_stop(frm_stop),
   .frm_abort(frm_abort), .rx_valid(rx_valid), .pay_valid(pay_valid),
   .done(done), .err_code(err_code)
);

// File: tb/frame_guard_tb_top.sv
module frame_guard_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_LEN    = 8;
   localparam int BYTE_CYC   = 4;
   localparam int TMO_BYTES  = 3;
   localparam int LIMIT      = BYTE_CYC * TMO_BYTES;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frm_start = 1'b0, frm_stop = 1'b0, frm_abort = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       pay_valid, done;
   logic [7:0] pay_data;
   logic [2:0] err_code;

   int checks = 0, errors = 0;
   int cyc = 0, drv_cyc = 0;
   int pay_n = 0, done_n = 0, done_cyc = 0;
   logic [2:0] last_code = '0;
   logic [7:0] pay_q [0:63];
   logic [7:0] fr [0:63];
   int fr_n = 0;

   frame_guard #(.MAX_LEN(MAX_LEN), .BYTE_CYCLES(BYTE_CYC),
                 .TIMEOUT_BYTES(TMO_BYTES)) dut_i (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_stop(frm_stop),
      .frm_abort(frm_abort), .rx_valid(rx_valid), .rx_data(rx_data),
      .pay_valid(pay_valid), .pay_data(pay_data), .done(done), .err_code(err_code)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      #1;
      cyc <= cyc + 1;
      if (pay_valid && pay_n < 64) begin pay_q[pay_n] = pay_data; pay_n++; end
      if (done) begin done_n++; last_code = err_code; done_cyc = cyc + 1; end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_of(input int n);
      logic [15:0] c = 16'hFFFF;
      for (int i = 0; i < n; i++) begin
         c ^= {fr[i], 8'h00};
         for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
      end
      return c;
   endfunction

   task automatic mon_clear(); pay_n = 0; done_n = 0; last_code = '0; endtask
   task automatic fr_clear(); fr_n = 0; endtask
   task automatic fr_push(input logic [7:0] b); fr[fr_n] = b; fr_n++; endtask
   task automatic fr_seal(); logic [15:0] c; c = crc_of(fr_n); fr_push(c[15:8]); fr_push(c[7:0]); endtask

   task automatic pulse_start(); frm_start = 1; @(negedge clk); frm_start = 0; @(negedge clk); endtask
   task automatic pulse_stop();  drv_cyc = cyc; frm_stop = 1; @(negedge clk); frm_stop = 0; @(negedge clk); endtask
   task automatic put_byte(input logic [7:0] b);
      drv_cyc = cyc; rx_valid = 1; rx_data = b; @(negedge clk); rx_valid = 0; @(negedge clk);
   endtask
   task automatic put_frame(input int n); for (int i = 0; i < n; i++) put_byte(fr[i]); endtask
   task automatic settle(); repeat (3) @(negedge clk); endtask

   task automatic t_reset();
      check(!done && !pay_valid && err_code == 0, "R1 reset outputs", {done, pay_valid, err_code}, 0);
   endtask

   task automatic t_good();
      mon_clear(); fr_clear();
      fr_push(8'h42); fr_push(8'd3); fr_push(8'h11); fr_push(8'h22); fr_push(8'h33); fr_seal();
      pulse_start(); put_frame(fr_n); pulse_stop(); settle();
      check(pay_n == 3, "R2 payload count", pay_n, 3);
      check(pay_q[0] == 8'h11 && pay_q[1] == 8'h22 && pay_q[2] == 8'h33, "R2 payload order", pay_q[2], 8'h33);
      check(done_n == 1 && last_code == 0, "R2 ok verdict", last_code, 0);
      check(done_cyc == drv_cyc + 1, "R2 verdict cycle", done_cyc, drv_cyc + 1);
   endtask

   task automatic t_max_len();
      mon_clear(); fr_clear();
      fr_push(8'h10); fr_push(8'(MAX_LEN));
      for (int i = 0; i < MAX_LEN; i++) fr_push(8'(i + 1));
      fr_seal();
      pulse_start(); put_frame(fr_n); pulse_stop(); settle();
      check(pay_n == MAX_LEN && done_n == 1 && last_code == 0, "R3 count at MAX_LEN accepted", last_code, 0);
   endtask

   task automatic t_len(input logic [7:0] cnt);
      int dc;
      mon_clear();
      pulse_start(); put_byte(8'h20); put_byte(cnt); dc = drv_cyc;
      put_byte(8'h01); put_byte(8'h02); pulse_stop(); settle();
      check(done_n == 1 && last_code == 1, "R3 length verdict", last_code, 1);
      check(done_cyc == dc + 1, "R3 length verdict cycle", done_cyc, dc + 1);
      check(pay_n == 0, "R3 no payload after length error", pay_n, 0);
   endtask

   task automatic t_short();
      mon_clear(); fr_clear();
      fr_push(8'h30); fr_push(8'd2); fr_push(8'hAA); fr_push(8'hBB); fr_seal();
      pulse_start(); put_frame(fr_n - 1); pulse_stop(); settle();
      check(done_n == 1 && last_code == 2, "R4 short frame", last_code, 2);
   endtask

   task automatic t_overrun();
      int dc;
      mon_clear(); fr_clear();
      fr_push(8'h31); fr_push(8'd1); fr_push(8'h5C); fr_seal();
      pulse_start(); put_frame(fr_n); put_byte(8'h00); dc = drv_cyc; pulse_stop(); settle();
      check(done_n == 1 && last_code == 3, "R5 overrun verdict", last_code, 3);
      check(done_cyc == dc + 1, "R5 overrun cycle", done_cyc, dc + 1);
   endtask

   task automatic t_crc_bad(input logic [7:0] b0, input logic [7:0] b1);
      mon_clear(); fr_clear();
      fr_push(8'h44); fr_push(8'd2); fr_push(b0); fr_push(b1); fr_seal();
      fr[fr_n - 1] = fr[fr_n - 1] ^ 8'h01;
      pulse_start(); put_frame(fr_n); pulse_stop(); settle();
      check(done_n == 1 && last_code == 4, "R6 crc mismatch", last_code, 4);
   endtask

   task automatic t_crc_swapped();
      logic [7:0] t;
      mon_clear(); fr_clear();
      fr_push(8'h45); fr_push(8'd1); fr_push(8'h77); fr_seal();
      t = fr[fr_n - 1]; fr[fr_n - 1] = fr[fr_n - 2]; fr[fr_n - 2] = t;
      pulse_start(); put_frame(fr_n); pulse_stop(); settle();
      check(done_n == 1 && last_code == 4, "R6 low byte first rejected", last_code, 4);
   endtask

   task automatic t_pair(input logic [7:0] b0, input logic [7:0] b1, input logic [2:0] exp);
      mon_clear(); fr_clear();
      fr_push(8'h50); fr_push(8'd3); fr_push(b0); fr_push(b1); fr_push(8'h99); fr_seal();
      pulse_start(); put_frame(fr_n); pulse_stop(); settle();
      check(done_n == 1 && last_code == exp, "R7 complement rule", last_code, exp);
   endtask

   task automatic t_abort();
      mon_clear(); fr_clear();
      pulse_start(); put_byte(8'h60); put_byte(8'd2); put_byte(8'h01);
      frm_abort = 1; @(negedge clk); frm_abort = 0;
      repeat (LIMIT + 4) @(negedge clk);
      check(done_n == 0, "R8 abort gives no verdict", done_n, 0);
      fr_push(8'h61); fr_push(8'd1); fr_push(8'h0F); fr_seal();
      mon_clear();
      pulse_start(); put_frame(fr_n); pulse_stop(); settle();
      check(done_n == 1 && last_code == 0, "R8 frame after abort", last_code, 0);
   endtask

   task automatic t_timeout();
      int dc;
      mon_clear();
      pulse_start(); put_byte(8'h70); put_byte(8'd2); dc = drv_cyc;
      repeat (LIMIT + 4) @(negedge clk);
      check(done_n == 1 && last_code == 6, "R9 timeout verdict", last_code, 6);
      check(done_cyc == dc + 1 + LIMIT, "R9 timeout cycle", done_cyc, dc + 1 + LIMIT);
      pulse_stop(); settle();
      check(done_n == 1, "R9 stop after timeout silent", done_n, 1);
   endtask

   task automatic t_restart();
      mon_clear(); fr_clear();
      pulse_start(); put_byte(8'h80); put_byte(8'd3); put_byte(8'hF1);
      fr_push(8'h81); fr_push(8'd1); fr_push(8'h3C); fr_seal();
      pulse_start(); put_frame(fr_n); pulse_stop(); settle();
      check(done_n == 1 && last_code == 0, "R10 repeated start restarts", last_code, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1; @(negedge clk);
            t_reset();
            t_good();
            t_max_len();
            t_len(8'd0);
            t_len(8'(MAX_LEN + 1));
            t_short();
            t_overrun();
            t_crc_bad(8'h12, 8'h34);
            t_crc_bad(8'hF5, 8'h00);
            t_crc_swapped();
            t_pair(8'hF5, 8'h0A, 3'd0);
            t_pair(8'hF5, 8'h0B, 3'd5);
            t_pair(8'hFF, 8'h01, 3'd5);
            t_pair(8'hEF, 8'h34, 3'd0);
            t_abort();
            t_timeout();
            t_restart();
         end
         begin
            repeat (20000) @(negedge clk);
            check(0, "watchdog expired", 0, 1);
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule